// File: doc/BRIEF.md
# Flash Erase and Program Sequencer

This block is the control side of a byte-wide flash store. It takes single-byte program requests and erase requests at three sizes (one sector, one block of sixteen sectors, or the whole store), checks each request against the write-protect state, and runs each accepted operation for a fixed number of clock cycles. The storage itself is a behavioural array in which each operation's timing is expressed as a cycle count.

Protection comes from three sources. A top-block guard input covers only the highest block. A main guard input covers every other block. A per-block lock bit can protect any block, but the lock bits count only while the mode input selects the firmware-hub style of access.

While an operation runs, a read returns a status byte instead of array data. Bit 7 of that byte is a polling bit, and bit 6 flips on each status read. When the block is idle, reads return the stored bytes. Bus-cycle decoding and any unlock command sequence belong to the surrounding logic. A parent drives this block through a plain request strobe and watches `busy` and `done`.

Top module: `flash_seq`

## Requirements
- R1: The address space is split into BLOCKS blocks of SECS_PER_BLK sectors of SEC_BYTES bytes. The block index is the top log2(BLOCKS) address bits and the sector index is the address shifted right by log2(SEC_BYTES). After reset every byte reads 0xFF.
- R2: A sector erase (req_op = 1) sets every byte of the addressed sector to 0xFF and leaves all other bytes unchanged, including the bytes on either side of the sector's edges.
- R3: A block erase (req_op = 2) sets every byte of the addressed block to 0xFF and leaves other blocks unchanged. A chip erase (req_op = 3) sets every byte to 0xFF.
- R4: A program (req_op = 0) replaces the stored byte with the old value AND req_data, so programming can only clear bits.
- R5: While top_guard is 1, no program or erase of the highest block starts. A chip erase does not start either.
- R6: While main_guard is 1, no program or erase of any block other than the highest starts.
- R7: A lock bit written through lock_we/lock_sel/lock_set protects its block only while mode_fwh is 1. A chip erase does not start while any block is protected.
- R8: An accepted request raises busy on the next cycle. busy stays high for PROG_CYCLES cycles for a program and ERASE_CYCLES cycles for an erase. done is high for exactly the one cycle after busy falls. A rejected request never raises busy.
- R9: A read issued while busy returns, one cycle later, a status byte. Bit 7 is the inverse of req_data bit 7 during a program and 0 during an erase. Bit 6 inverts on each successive busy read. Bits 5..0 are 0.
- R10: Requests that arrive while busy are ignored and change no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | ADDR_W | Target byte address |
| req_data | input | 8 | Program data |
| mode_fwh | input | 1 | 1 selects firmware-hub mode, in which lock bits are honoured |
| top_guard | input | 1 | Protects the highest block |
| main_guard | input | 1 | Protects all blocks but the highest |
| lock_we | input | 1 | Lock bit write strobe |
| lock_sel | input | BLK_W | Block whose lock bit is written |
| lock_set | input | 1 | Value written to the lock bit |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read result, valid the cycle after rd_en |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle that done follows the last busy cycle, that a rejected request leaves the block idle, and that the captured job stays frozen while the countdown runs. They also check that consecutive busy reads flip the toggle bit, that a program never sets a bit, and that a chip erase leaves the read port at 0xFF. Whether an erase stops exactly at sector and block edges, whether each protection source blocks the right blocks under each mode, and whether the busy window has the exact length can only be shown by the bench's scenarios. Those scenarios compare the bytes read back, and the measured busy lengths, against an independent model of the store.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG       = 2'd0,
        OP_SEC_ERASE  = 2'd1,
        OP_BLK_ERASE  = 2'd2,
        OP_CHIP_ERASE = 2'd3
    } fop_e;

    typedef struct packed {
        fop_e       op;
        logic [7:0] data;
    } job_t;

    localparam logic [7:0] BLANK_BYTE = 8'hFF;

    // Polling level shown while busy: inverse of the final bit 7.
    function automatic logic poll_level(fop_e op, logic [7:0] d);
        return (op == OP_PROG) ? ~d[7] : 1'b0;
    endfunction

    function automatic logic [7:0] status_byte(logic poll, logic tog);
        return {poll, tog, 6'b000000};
    endfunction

endpackage

// File: rtl/flash_guard.sv
module flash_guard
    import flash_seq_pkg::*;
#(
    parameter int BLOCKS = 8,
    localparam int BLK_W = $clog2(BLOCKS)
) (
    input  fop_e               op,
    input  logic [BLK_W-1:0]   blk,
    input  logic               mode_fwh,
    input  logic               top_guard,
    input  logic               main_guard,
    input  logic [BLOCKS-1:0]  lock_bits,
    output logic               blocked
);
    logic [BLOCKS-1:0] prot;

    for (genvar b = 0; b < BLOCKS; b++) begin : g_prot
        if (b == BLOCKS - 1) begin : g_top
            assign prot[b] = top_guard | (mode_fwh & lock_bits[b]);
        end else begin : g_main
            assign prot[b] = main_guard | (mode_fwh & lock_bits[b]);
        end
    end

    assign blocked = (op == OP_CHIP_ERASE) ? (|prot) : prot[blk];

endmodule

// File: rtl/flash_store.sv
module flash_store
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int SEC_SH = 4,
    parameter int BLK_SH = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  fop_e              op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte
);
    logic [7:0]       mem [DEPTH];
    logic [DEPTH-1:0] hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_hit
        localparam logic [ADDR_W-1:0] GA = ADDR_W'(g);
        assign hit[g] = (op == OP_CHIP_ERASE)
                      | ((op == OP_BLK_ERASE) & (GA[ADDR_W-1:BLK_SH] == addr[ADDR_W-1:BLK_SH]))
                      | ((op == OP_SEC_ERASE) & (GA[ADDR_W-1:SEC_SH] == addr[ADDR_W-1:SEC_SH]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK_BYTE;
        end else if (commit) begin
            if (op == OP_PROG) begin
                mem[addr] <= mem[addr] & data;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (hit[i]) mem[i] <= BLANK_BYTE;
                end
            end
        end
    end

    assign rd_byte = mem[rd_addr];

    // R4: a program never turns a 0 bit into a 1
    a_r4_prog_only_clears: assert property (@(posedge clk) disable iff (rst)
        commit && op == OP_PROG && rd_addr == addr
        |=> !$stable(rd_addr) || ((rd_byte & ~$past(rd_byte)) == 8'h00));

    // R3: after a chip erase any byte reads blank
    a_r3_chip_blank: assert property (@(posedge clk) disable iff (rst)
        commit && op == OP_CHIP_ERASE |=> rd_byte == BLANK_BYTE);

endmodule

// File: rtl/flash_status.sv
module flash_status
    import flash_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_en,
    input  logic       busy,
    input  job_t       job,
    input  logic [7:0] rd_byte,
    output logic [7:0] rd_data
);
    logic tog;

    always_ff @(posedge clk) begin
        if (rst) begin
            tog     <= 1'b0;
            rd_data <= 8'h00;
        end else if (rd_en) begin
            if (busy) begin
                rd_data <= status_byte(poll_level(job.op, job.data), tog);
                tog     <= ~tog;
            end else begin
                rd_data <= rd_byte;
            end
        end
    end

    // R9: back-to-back busy reads show opposite toggle bits
    a_r9_toggle_flips: assert property (@(posedge clk) disable iff (rst)
        rd_en && busy && $past(rd_en && busy) |=> rd_data[6] != $past(rd_data[6]));

    // R9: unused status bits read zero
    a_r9_status_pad: assert property (@(posedge clk) disable iff (rst)
        rd_en && busy |=> rd_data[5:0] == 6'b0);

endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int SEC_BYTES    = 16,
    parameter int SECS_PER_BLK = 16,
    parameter int BLOCKS       = 8,
    parameter int PROG_CYCLES  = 825,
    parameter int ERASE_CYCLES = 1650000,
    localparam int SEC_SH  = $clog2(SEC_BYTES),
    localparam int BLK_SH  = $clog2(SEC_BYTES * SECS_PER_BLK),
    localparam int ADDR_W  = $clog2(SEC_BYTES * SECS_PER_BLK * BLOCKS),
    localparam int BLK_W   = $clog2(BLOCKS),
    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES,
    localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic              mode_fwh,
    input  logic              top_guard,
    input  logic              main_guard,
    input  logic              lock_we,
    input  logic [BLK_W-1:0]  lock_sel,
    input  logic              lock_set,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              done
);
    fop_e              req_kind;
    logic              blocked;
    logic              start;
    logic              commit;
    logic [BLOCKS-1:0] lock_q;
    logic [CNT_W-1:0]  cnt;
    job_t              job;
    logic [ADDR_W-1:0] job_addr;
    logic [7:0]        rd_byte;

    assign req_kind = fop_e'(req_op);

    flash_guard #(.BLOCKS(BLOCKS)) u_guard (
        .op         (req_kind),
        .blk        (req_addr[ADDR_W-1:BLK_SH]),
        .mode_fwh   (mode_fwh),
        .top_guard  (top_guard),
        .main_guard (main_guard),
        .lock_bits  (lock_q),
        .blocked    (blocked)
    );

    assign start  = req_valid && !busy && !blocked;
    assign commit = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            cnt      <= '0;
            job      <= '{op: OP_PROG, data: 8'h00};
            job_addr <= '0;
            lock_q   <= '0;
        end else begin
            done <= 1'b0;
            if (lock_we) lock_q[lock_sel] <= lock_set;
            if (start) begin
                busy     <= 1'b1;
                cnt      <= (req_kind == OP_PROG) ? CNT_W'(PROG_CYCLES - 1)
                                                  : CNT_W'(ERASE_CYCLES - 1);
                job      <= '{op: req_kind, data: req_data};
                job_addr <= req_addr;
            end else if (busy) begin
                if (cnt == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    flash_store #(.ADDR_W(ADDR_W), .SEC_SH(SEC_SH), .BLK_SH(BLK_SH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .op      (job.op),
        .addr    (job_addr),
        .data    (job.data),
        .rd_addr (rd_addr),
        .rd_byte (rd_byte)
    );

    flash_status u_status (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .busy    (busy),
        .job     (job),
        .rd_byte (rd_byte),
        .rd_data (rd_data)
    );

    // R8: done marks the cycle right after the last busy cycle
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && $past(busy));

    // R5 / R6 / R7: a protected request leaves the block idle
    a_r5_blocked_stays_idle: assert property (@(posedge clk) disable iff (rst)
        req_valid && !busy && blocked |=> !busy);

    // R10: the running job cannot be replaced mid-flight
    a_r10_job_frozen: assert property (@(posedge clk) disable iff (rst)
        busy && cnt != '0 |=> busy && $stable(job) && $stable(job_addr));

endmodule

// File: tb/tb_flash_seq.sv
module tb_flash_seq;
    import flash_seq_pkg::*;

    localparam int PC    = 6;
    localparam int EC    = 12;
    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = 8'h00;
    logic          mode_fwh = 1'b0;
    logic          top_guard = 1'b0;
    logic          main_guard = 1'b0;
    logic          lock_we = 1'b0;
    logic [2:0]    lock_sel = 3'd0;
    logic          lock_set = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          busy;
    logic          done;

    always #2 clk = ~clk;

    flash_seq #(.PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .mode_fwh(mode_fwh),
        .top_guard(top_guard), .main_guard(main_guard), .lock_we(lock_we),
        .lock_sel(lock_sel), .lock_set(lock_set), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done)
    );

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [7:0] exp;
        logic [7:0] mask;
        string      tag;
    } item_t;

    item_t      sb[$];
    logic [7:0] model [DEPTH];
    logic       rd_fire = 1'b0;
    logic [7:0] prev_rd = 8'h00;
    logic [7:0] cur_rd  = 8'h00;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) rd_fire <= rd_en;

    // monitor: pop the expected item for each completed read
    always @(negedge clk) begin
        if (rd_fire) begin
            prev_rd = cur_rd;
            cur_rd  = rd_data;
            if (sb.size() == 0) begin
                check(1'b0, "scoreboard empty", rd_data, 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check((rd_data & it.mask) == (it.exp & it.mask), it.tag,
                      rd_data & it.mask, it.exp & it.mask);
            end
        end
    end

    task automatic rd(input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = a;
        sb.push_back('{exp: model[a], mask: 8'hFF, tag: tag});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic model_apply(input fop_e op, input logic [AW-1:0] a, input logic [7:0] d);
        for (int i = 0; i < DEPTH; i++) begin
            case (op)
                OP_PROG:       if (i == int'(a)) model[i] = model[i] & d;
                OP_SEC_ERASE:  if ((i >> 4) == (int'(a) >> 4)) model[i] = 8'hFF;
                OP_BLK_ERASE:  if ((i >> 8) == (int'(a) >> 8)) model[i] = 8'hFF;
                default:       model[i] = 8'hFF;
            endcase
        end
    endtask

    task automatic run_op(input fop_e op, input logic [AW-1:0] a, input logic [7:0] d,
                          input bit exp_start, input bit probe, input string tag);
        int n;
        logic [7:0] poll;
        poll = (op == OP_PROG) ? {~d[7], 7'b0} : 8'h00;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = 2'(op);
        req_addr  = a;
        req_data  = d;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == exp_start, {tag, " start"}, busy, exp_start);
        if (exp_start) begin
            n = 0;
            while (busy && n < 1000) begin
                n++;
                rd_en     = 1'b0;
                req_valid = 1'b0;
                if (probe && (n == 1 || n == 2)) begin
                    rd_en   = 1'b1;
                    rd_addr = a;
                    sb.push_back('{exp: poll, mask: 8'hBF, tag: "R9 status byte"});
                end
                if (probe && n == 3) begin
                    req_valid = 1'b1;
                    req_op    = 2'(OP_PROG);
                    req_addr  = a ^ 11'h040;
                    req_data  = 8'h00;
                end
                @(negedge clk);
            end
            rd_en     = 1'b0;
            req_valid = 1'b0;
            check(n == ((op == OP_PROG) ? PC : EC), {tag, " R8 busy length"}, n,
                  (op == OP_PROG) ? PC : EC);
            check(done == 1'b1, "R8 done rises", done, 1);
            if (probe) check(cur_rd[6] != prev_rd[6], "R9 toggle", cur_rd[6], ~prev_rd[6]);
            model_apply(op, a, d);
            @(negedge clk);
            check(done == 1'b0, "R8 done one cycle", done, 0);
        end else begin
            repeat (2) begin
                @(negedge clk);
                check(busy == 1'b0, {tag, " stays idle"}, busy, 0);
            end
        end
    endtask

    task automatic set_lock(input logic [2:0] b, input logic v);
        @(negedge clk);
        lock_we  = 1'b1;
        lock_sel = b;
        lock_set = v;
        @(negedge clk);
        lock_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R8 reset busy", busy, 0);
        check(done == 1'b0, "R8 reset done", done, 0);
        rd(11'h000, "R1 blank after reset");
        rd(11'h7FF, "R1 blank after reset top");

        // program with status probing and an ignored mid-flight request
        run_op(OP_PROG, 11'h010, 8'h5A, 1'b1, 1'b1, "R8 program");
        rd(11'h010, "R4 program value");
        rd(11'h050, "R10 busy request ignored");
        run_op(OP_PROG, 11'h010, 8'h0F, 1'b1, 1'b0, "R4 second program");
        rd(11'h010, "R4 AND of old and new");

        // sector erase with neighbours on both sides
        run_op(OP_PROG, 11'h00F, 8'h00, 1'b1, 1'b0, "R2 setup low");
        run_op(OP_PROG, 11'h020, 8'h00, 1'b1, 1'b0, "R2 setup high");
        run_op(OP_SEC_ERASE, 11'h015, 8'h00, 1'b1, 1'b1, "R2 sector erase");
        rd(11'h010, "R2 sector erased");
        rd(11'h00F, "R1 R2 byte below sector kept");
        rd(11'h020, "R1 R2 byte above sector kept");
        rd(11'h055, "R10 ignored during erase");

        // block erase
        run_op(OP_PROG, 11'h100, 8'h33, 1'b1, 1'b0, "R3 setup");
        run_op(OP_BLK_ERASE, 11'h0AB, 8'h00, 1'b1, 1'b0, "R3 block erase");
        rd(11'h020, "R3 block erased");
        rd(11'h00F, "R3 block erased low");
        rd(11'h100, "R3 next block kept");

        // top guard
        top_guard = 1'b1;
        run_op(OP_PROG, 11'h7F0, 8'h00, 1'b0, 1'b0, "R5 top program dropped");
        rd(11'h7F0, "R5 top byte unchanged");
        run_op(OP_BLK_ERASE, 11'h700, 8'h00, 1'b0, 1'b0, "R5 top erase dropped");
        run_op(OP_CHIP_ERASE, 11'h000, 8'h00, 1'b0, 1'b0, "R5 chip erase dropped");
        rd(11'h100, "R5 data kept after dropped chip erase");
        run_op(OP_PROG, 11'h200, 8'h44, 1'b1, 1'b0, "R5 other block allowed");
        rd(11'h200, "R5 other block programmed");
        top_guard = 1'b0;

        // main guard
        main_guard = 1'b1;
        run_op(OP_PROG, 11'h300, 8'h11, 1'b0, 1'b0, "R6 main program dropped");
        rd(11'h300, "R6 main byte unchanged");
        run_op(OP_SEC_ERASE, 11'h200, 8'h00, 1'b0, 1'b0, "R6 main erase dropped");
        rd(11'h200, "R6 main data kept");
        run_op(OP_PROG, 11'h7F0, 8'h12, 1'b1, 1'b0, "R6 top block allowed");
        rd(11'h7F0, "R6 top block programmed");
        main_guard = 1'b0;

        // lock bits, honoured only in firmware-hub mode
        set_lock(3'd3, 1'b1);
        mode_fwh = 1'b0;
        run_op(OP_PROG, 11'h301, 8'h21, 1'b1, 1'b0, "R7 lock ignored outside mode");
        rd(11'h301, "R7 program through ignored lock");
        mode_fwh = 1'b1;
        run_op(OP_PROG, 11'h302, 8'h22, 1'b0, 1'b0, "R7 locked program dropped");
        rd(11'h302, "R7 locked byte unchanged");
        run_op(OP_CHIP_ERASE, 11'h000, 8'h00, 1'b0, 1'b0, "R7 chip erase with lock dropped");
        rd(11'h100, "R7 data kept");
        run_op(OP_PROG, 11'h400, 8'h66, 1'b1, 1'b0, "R7 unlocked block allowed");
        set_lock(3'd3, 1'b0);
        run_op(OP_CHIP_ERASE, 11'h000, 8'h00, 1'b1, 1'b1, "R3 chip erase");
        rd(11'h100, "R3 chip erased a");
        rd(11'h7F0, "R3 chip erased b");
        rd(11'h301, "R3 chip erased c");
        rd(11'h400, "R3 chip erased d");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "scoreboard drained", sb.size(), 0);
        finish_run();
    end

endmodule